// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a virtual page number into a physical frame number by walking a two-level page table held in memory. The page number is split into an upper index and a lower index. The walker adds the upper index to a table base to fetch a directory entry. If that entry is valid, its low bits give the base of a leaf table. The walker then adds the lower index to that base to fetch the leaf entry. It returns the frame number with its dirty and reference flags, or it returns a fault.

A requester sees a ready/valid request channel and a one-cycle response pulse. The byte offset of the address never reaches the walker. Memory is reached through a plain synchronous read port with one cycle of latency. The walker has at most one read in flight, because the second address depends on the data returned by the first read.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `req_ready` is 1 and `mem_rd_en` and `rsp_done` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle the walker raises `mem_rd_en` for one cycle, with address `pt_base + req_vpn[9:5]`. Both values are sampled at acceptance.
- R3: The directory entry uses bit 15 as its valid bit and bits 14:0 as the leaf table base. When the entry is valid, the walker presents the second read two cycles after the first, at address `entry[14:0] + req_vpn[4:0]`.
- R4: A directory entry with bit 15 clear makes the walker skip the second read. `rsp_done` then rises three edges after the accept edge, with `rsp_fault`=1 and frame, dirty and reference all 0.
- R5: A leaf entry with bit 15 (resident) clear gives `rsp_fault`=1, with frame, dirty and reference forced to 0 whatever the other bits of the entry hold.
- R6: A resident leaf entry gives `rsp_fault`=0, `rsp_frame`=entry[5:0], `rsp_dirty`=entry[14] and `rsp_ref`=entry[13]. On any two-read walk, `rsp_done` rises five edges after the accept edge.
- R7: `rsp_done` is high for exactly one cycle, and `req_ready` is high again in the cycle that follows it.
- R8: From acceptance until the end of the response cycle, `req_ready` is 0, and `req_valid` together with any change of `req_vpn` has no effect: no extra read and no extra response appear.
- R9: Reads are strictly sequential: `mem_rd_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and will accept a request |
| req_vpn | input | 10 | Virtual page number: upper index in [9:5], lower index in [4:0] |
| pt_base | input | 16 | Base address of the directory table |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read word address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the strobe |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation failed at either level |
| rsp_frame | output | 6 | Physical frame number (0 on fault) |
| rsp_dirty | output | 1 | Leaf dirty flag (0 on fault) |
| rsp_ref | output | 1 | Leaf reference flag (0 on fault) |

## Verification
Counting from the accept edge, the first read strobe is due one edge later. The dependent second read is due three edges after acceptance. The response pulse rises after three edges when the walk faults at the directory and after five edges on any two-read walk. The driver stamps each request with the cycle count at the falling edge before acceptance and queues the expected read addresses and the expected response, including its latency. Monitors sample on falling edges, pop each read and each response as it appears, and compare both the value and the elapsed cycle count, so a read or response that comes early, late or extra is reported.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_WAIT_L1 = 3'd2,
    ST_READ_L2 = 3'd3,
    ST_WAIT_L2 = 3'd4,
    ST_RESPOND = 3'd5
  } walk_state_e;

endpackage

// File: rtl/ptw_vpn_split.sv
module ptw_vpn_split #(
  parameter int IDX1_W = 5,
  parameter int IDX2_W = 5,
  localparam int VPN_W = IDX1_W + IDX2_W
) (
  input  logic [VPN_W-1:0]  vpn,
  output logic [IDX1_W-1:0] idx_dir,
  output logic [IDX2_W-1:0] idx_leaf
);

  // upper field selects the directory slot, lower field the leaf slot
  assign idx_dir  = vpn[VPN_W-1 -: IDX1_W];
  assign idx_leaf = vpn[IDX2_W-1:0];

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int ENT_W   = 16,
  parameter int MADDR_W = 16,
  parameter int FRAME_W = 6
) (
  input  logic [ENT_W-1:0]   entry,
  output logic               dir_valid,
  output logic [MADDR_W-1:0] dir_base,
  output logic               leaf_present,
  output logic               leaf_dirty,
  output logic               leaf_ref,
  output logic [FRAME_W-1:0] leaf_frame
);

  localparam int BASE_W = ENT_W - 1;

  // directory view: top bit valid, everything below is the table base
  assign dir_valid = entry[ENT_W-1];

  generate
    if (BASE_W >= MADDR_W) begin : g_base_trunc
      assign dir_base = entry[MADDR_W-1:0];
    end else begin : g_base_ext
      assign dir_base = {{(MADDR_W-BASE_W){1'b0}}, entry[BASE_W-1:0]};
    end
  endgenerate

  // leaf view: resident, dirty, reference in the three top bits
  assign leaf_present = entry[ENT_W-1];
  assign leaf_dirty   = entry[ENT_W-2];
  assign leaf_ref     = entry[ENT_W-3];
  assign leaf_frame   = entry[FRAME_W-1:0];

endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
#(
  parameter int IDX1_W  = 5,
  parameter int IDX2_W  = 5,
  parameter int MADDR_W = 16,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [MADDR_W-1:0] pt_base,
  input  logic [IDX1_W-1:0]  idx_dir,
  input  logic [IDX2_W-1:0]  idx_leaf,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic               dir_valid,
  input  logic [MADDR_W-1:0] dir_base,
  input  logic               leaf_present,
  input  logic               leaf_dirty,
  input  logic               leaf_ref,
  input  logic [FRAME_W-1:0] leaf_frame,
  output logic               rsp_done,
  output logic               rsp_fault,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_dirty,
  output logic               rsp_ref
);

  walk_state_e       state_q;
  logic [IDX2_W-1:0] leaf_idx_q;

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      leaf_idx_q  <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rsp_done    <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_frame   <= '0;
      rsp_dirty   <= 1'b0;
      rsp_ref     <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      rsp_done  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            leaf_idx_q  <= idx_leaf;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= pt_base + MADDR_W'(idx_dir);
            state_q     <= ST_READ_L1;
          end
        end
        ST_READ_L1: state_q <= ST_WAIT_L1;
        ST_WAIT_L1: begin
          if (dir_valid) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= dir_base + MADDR_W'(leaf_idx_q);
            state_q     <= ST_READ_L2;
          end else begin
            rsp_done  <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_frame <= '0;
            rsp_dirty <= 1'b0;
            rsp_ref   <= 1'b0;
            state_q   <= ST_RESPOND;
          end
        end
        ST_READ_L2: state_q <= ST_WAIT_L2;
        ST_WAIT_L2: begin
          rsp_done <= 1'b1;
          state_q  <= ST_RESPOND;
          if (leaf_present) begin
            rsp_fault <= 1'b0;
            rsp_frame <= leaf_frame;
            rsp_dirty <= leaf_dirty;
            rsp_ref   <= leaf_ref;
          end else begin
            rsp_fault <= 1'b1;
            rsp_frame <= '0;
            rsp_dirty <= 1'b0;
            rsp_ref   <= 1'b0;
          end
        end
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_issues_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && !req_ready));

  // R9
  rd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R3
  second_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_L1 && dir_valid) |=> mem_rd_en);

  // R4
  dir_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_L1 && !dir_valid) |=> (rsp_done && rsp_fault && !mem_rd_en));

  // R5
  fault_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_fault) |-> (rsp_frame == '0 && !rsp_dirty && !rsp_ref));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && req_ready));

  // R8
  busy_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done || state_q == ST_READ_L2) |=> !mem_rd_en);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int IDX1_W  = 5,
  parameter int IDX2_W  = 5,
  parameter int ENT_W   = 16,
  parameter int MADDR_W = 16,
  parameter int FRAME_W = 6,
  localparam int VPN_W  = IDX1_W + IDX2_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [MADDR_W-1:0] pt_base,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [ENT_W-1:0]   mem_rd_data,
  output logic               rsp_done,
  output logic               rsp_fault,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_dirty,
  output logic               rsp_ref
);

  logic [IDX1_W-1:0]  idx_dir;
  logic [IDX2_W-1:0]  idx_leaf;
  logic               dir_valid;
  logic [MADDR_W-1:0] dir_base;
  logic               leaf_present;
  logic               leaf_dirty;
  logic               leaf_ref;
  logic [FRAME_W-1:0] leaf_frame;

  ptw_vpn_split #(
    .IDX1_W(IDX1_W),
    .IDX2_W(IDX2_W)
  ) split_i (
    .vpn     (req_vpn),
    .idx_dir (idx_dir),
    .idx_leaf(idx_leaf)
  );

  ptw_pte_decode #(
    .ENT_W  (ENT_W),
    .MADDR_W(MADDR_W),
    .FRAME_W(FRAME_W)
  ) decode_i (
    .entry       (mem_rd_data),
    .dir_valid   (dir_valid),
    .dir_base    (dir_base),
    .leaf_present(leaf_present),
    .leaf_dirty  (leaf_dirty),
    .leaf_ref    (leaf_ref),
    .leaf_frame  (leaf_frame)
  );

  ptw_walk_ctrl #(
    .IDX1_W (IDX1_W),
    .IDX2_W (IDX2_W),
    .MADDR_W(MADDR_W),
    .FRAME_W(FRAME_W)
  ) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .pt_base     (pt_base),
    .idx_dir     (idx_dir),
    .idx_leaf    (idx_leaf),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .dir_valid   (dir_valid),
    .dir_base    (dir_base),
    .leaf_present(leaf_present),
    .leaf_dirty  (leaf_dirty),
    .leaf_ref    (leaf_ref),
    .leaf_frame  (leaf_frame),
    .rsp_done    (rsp_done),
    .rsp_fault   (rsp_fault),
    .rsp_frame   (rsp_frame),
    .rsp_dirty   (rsp_dirty),
    .rsp_ref     (rsp_ref)
  );

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_vpn = '0;
  logic [15:0] pt_base = '0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic        rsp_done, rsp_fault, rsp_dirty, rsp_ref;
  logic [5:0]  rsp_frame;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .pt_base(pt_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_frame(rsp_frame),
    .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
  );

  // memory model: one cycle read latency
  logic [15:0] pmem [0:4095];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pmem[mem_rd_addr[11:0]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit summary_done = 1'b0;

  typedef struct {
    logic       fault;
    logic [5:0] frame;
    logic       dirty;
    logic       refd;
    int         t0;
    int         lat;
  } exp_rsp_t;

  typedef struct {
    logic [15:0] addr;
    int          t0;
    int          lat;
  } exp_rd_t;

  exp_rsp_t rsp_q[$];
  exp_rd_t  rd_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic report();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    end
  endtask

  // driver: computes expectations from the table model, then issues the request
  task automatic issue(input logic [15:0] base, input logic [4:0] p1, input logic [4:0] p2,
                       input int hold);
    logic [15:0] a1, a2, e1, e2;
    exp_rsp_t er;
    exp_rd_t  ea;
    while (!req_ready) @(negedge clk);
    a1 = base + 16'(p1);
    e1 = pmem[a1[11:0]];
    ea.addr = a1; ea.t0 = cyc; ea.lat = 2;     // R2: strobe visible after 1st edge
    rd_q.push_back(ea);
    er.t0 = cyc;
    if (e1[15]) begin
      a2 = {1'b0, e1[14:0]} + 16'(p2);
      e2 = pmem[a2[11:0]];
      ea.addr = a2; ea.lat = 4;                // R3: second strobe after 3rd edge
      rd_q.push_back(ea);
      er.lat = 6;                              // R6: done after 5th edge
      if (e2[15]) begin
        er.fault = 1'b0; er.frame = e2[5:0]; er.dirty = e2[14]; er.refd = e2[13];
      end else begin
        er.fault = 1'b1; er.frame = '0; er.dirty = 1'b0; er.refd = 1'b0;   // R5
      end
    end else begin
      er.lat = 4;                              // R4: done after 3rd edge
      er.fault = 1'b1; er.frame = '0; er.dirty = 1'b0; er.refd = 1'b0;
    end
    rsp_q.push_back(er);
    req_valid = 1'b1;
    req_vpn   = {p1, p2};
    pt_base   = base;
    @(negedge clk);
    // R8: keep poking the walker while it is busy
    for (int i = 0; i < hold; i++) begin
      req_vpn = ~req_vpn;
      pt_base = pt_base + 16'h0010;
      chk(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // monitors, sampled on falling edges; cycle stamps count rising edges
  bit prev_rd = 1'b0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) begin
        chk(!prev_rd, "R9 back-to-back read", 1, 0);
        if (rd_q.size() == 0) begin
          chk(1'b0, "R8 unexpected read", int'(mem_rd_addr), -1);
        end else begin
          exp_rd_t x;
          x = rd_q.pop_front();
          chk(mem_rd_addr == x.addr, "R2/R3 read address", int'(mem_rd_addr), int'(x.addr));
          chk(cyc - x.t0 == x.lat - 1, "R2/R3 read timing", cyc - x.t0, x.lat - 1);
        end
      end
      if (prev_done)
        chk(!rsp_done && req_ready, "R7 done pulse width / ready after",
            int'(rsp_done), 0);
      if (rsp_done) begin
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected response", 1, 0);
        end else begin
          exp_rsp_t y;
          y = rsp_q.pop_front();
          chk(cyc - y.t0 == y.lat - 1, "R4/R6 response latency", cyc - y.t0, y.lat - 1);
          chk(rsp_fault == y.fault, "R4/R5/R6 fault", int'(rsp_fault), int'(y.fault));
          chk(rsp_frame == y.frame, "R5/R6 frame", int'(rsp_frame), int'(y.frame));
          chk({rsp_dirty, rsp_ref} == {y.dirty, y.refd}, "R5/R6 dirty/ref flags",
              int'({rsp_dirty, rsp_ref}), int'({y.dirty, y.refd}));
        end
      end
      prev_rd   = mem_rd_en;
      prev_done = rsp_done;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) pmem[i] = 16'h0000;
    // directory at 0x100
    pmem[12'h100] = 16'h8400;   // p1=0  -> leaf table 0x400
    pmem[12'h103] = 16'h8800;   // p1=3  -> 0x800
    pmem[12'h11F] = 16'h8C00;   // p1=31 -> 0xC00
    pmem[12'h105] = 16'h0400;   // p1=5  invalid (base bits set)
    pmem[12'h107] = 16'h8A00;   // p1=7  -> 0xA00
    // second directory at 0x200
    pmem[12'h201] = 16'h8400;
    // leaf tables
    pmem[12'h400] = 16'hA005;   // resident, ref, frame 5
    pmem[12'h409] = 16'hC02A;   // resident, dirty, frame 42
    pmem[12'h81F] = 16'hE03F;   // all flags, frame 63
    pmem[12'hC1F] = 16'h8001;   // resident, frame 1
    pmem[12'hA02] = 16'h403C;   // not resident, dirty set, frame 60

    // R1: reset state
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(mem_rd_en == 1'b0, "R1 no read in reset", int'(mem_rd_en), 0);
    chk(rsp_done == 1'b0, "R1 no done in reset", int'(rsp_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_rd_en && !rsp_done, "R1 idle after reset",
        int'({req_ready, mem_rd_en, rsp_done}), 4);

    issue(16'h0100, 5'd0,  5'd0,  0);   // R6 basic hit
    issue(16'h0100, 5'd0,  5'd9,  0);   // R6 dirty flag
    issue(16'h0100, 5'd3,  5'd31, 0);   // R3 max leaf index
    issue(16'h0100, 5'd31, 5'd31, 0);   // R2 max directory index
    issue(16'h0100, 5'd5,  5'd2,  0);   // R4 directory fault
    issue(16'h0100, 5'd7,  5'd2,  0);   // R5 leaf not resident
    issue(16'h0200, 5'd1,  5'd9,  0);   // R2 other base
    issue(16'h0100, 5'd0,  5'd0,  3);   // R8 request held during walk
    issue(16'h0100, 5'd5,  5'd0,  1);   // R8 held during a directory fault
    issue(16'h0100, 5'd31, 5'd31, 0);   // back-to-back after held request
    issue(16'h0100, 5'd12, 5'd4,  0);   // R4 empty directory slot

    repeat (12) @(negedge clk);
    chk(rsp_q.size() == 0, "R8 responses outstanding", rsp_q.size(), 0);
    chk(rd_q.size() == 0, "R2/R3 reads outstanding", rd_q.size(), 0);
    report();
    $finish;
  end

endmodule